// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit interval timer. Software reaches it through four word-aligned registers on a simple single-cycle read/write port. It writes a reload value to the period register, which also preloads the down-counter. It then sets a start bit in the control register to begin counting, and later sets a stop bit to halt it. Each write to the period register loads the counter immediately.

When the count runs out, the block raises a sticky timeout flag. In one-shot mode the counter then halts. In continuous mode it reloads from the period register and keeps going. A level interrupt follows the timeout flag whenever interrupts are enabled in the control register. Software clears the flag by writing any value to the status register. The live count can be read at any moment through a read-only snapshot register.

Top module: `cdt_timer`

## Requirements
- R1: After synchronous reset, every register reads zero, the counter is stopped and `irq` is 0.
- R2: The register is selected by the byte address shifted right by two. Word 0 is status, 1 is control, 2 is period and 3 is snapshot. Reads of unmapped words return zero. Writes to unmapped words and to the snapshot word change nothing.
- R3: In the status word, bit 0 is the timeout flag and bit 1 reads 1 while the counter runs. A write of any value to the status word clears bit 0 and leaves the run state alone.
- R4: The control word is stored exactly as written and reads back unchanged. A write with bit 2 set starts the counter, and a write with bit 3 set stops it. A write with both bits set leaves the counter stopped.
- R5: A write to the period word stores the value and also loads it into the counter on the same clock edge.
- R6: With control bit 1 clear, a counter started with period P (P ≥ 1) sets the timeout flag on the P-th clock edge after the start write. On that edge the counter drops to 0 and the run bit clears.
- R7: With control bit 1 set, expiry sets the timeout flag, reloads the counter from the period word and leaves it running, so the flag is set again every P clocks.
- R8: `irq` is a level equal to the timeout flag ANDed with control bit 0. It follows register writes and expiries one edge later.
- R9: A snapshot read returns the live count. While the counter is stopped, the count holds its value. A stop write takes effect after the decrement of its own edge.
- R10: A period of 0 or 1 expires on the first clock edge after the start write.
- R11: If an expiry and a status write fall on the same edge, the timeout flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read access |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus inputs are stable across each rising edge. They also assume that a write is a one-cycle pulse of `bus_sel` with `bus_we`, so that each access counts exactly once. The bench drives every input on the falling edge and holds each access for exactly one clock, which keeps the stimulus inside those assumptions. It also issues the same-edge collision of R11 on purpose, so the set-over-clear rule is exercised as well as asserted.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int unsigned CDT_DW    = 32;
    localparam int unsigned CDT_NREGS = 4;

    typedef logic [CDT_DW-1:0] word_t;

    typedef enum logic [1:0] {
        SLOT_STATUS   = 2'd0,
        SLOT_CONTROL  = 2'd1,
        SLOT_PERIOD   = 2'd2,
        SLOT_SNAPSHOT = 2'd3
    } slot_e;

    // control word bit positions
    localparam int unsigned CB_IRQ_EN = 0;
    localparam int unsigned CB_AUTO   = 1;
    localparam int unsigned CB_START  = 2;
    localparam int unsigned CB_HALT   = 3;

    // status word bit positions
    localparam int unsigned SB_TIMEOUT = 0;
    localparam int unsigned SB_RUN     = 1;

    typedef struct packed {
        logic status;
        logic control;
        logic period;
    } wstrobe_t;

    function automatic logic at_terminal(word_t c);
        return (c <= word_t'(1));
    endfunction

    function automatic word_t pack_status(logic timeout, logic running);
        word_t w;
        w = '0;
        w[SB_TIMEOUT] = timeout;
        w[SB_RUN]     = running;
        return w;
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  word_t             bus_wdata,
    input  word_t             status_word,
    input  word_t             count_val,
    output wstrobe_t          wstb,
    output word_t             ctrl_q,
    output word_t             period_q,
    output word_t             bus_rdata
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    slot_e            slot;
    logic             unused_lo;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign unused_lo = ^bus_addr[1:0];
    assign mapped    = ((idx >> 2) == '0);
    assign slot      = slot_e'(idx[1:0]);

    always_comb begin
        wstb = '0;
        if (bus_sel && bus_we && mapped) begin
            unique case (slot)
                SLOT_STATUS:   wstb.status  = 1'b1;
                SLOT_CONTROL:  wstb.control = 1'b1;
                SLOT_PERIOD:   wstb.period  = 1'b1;
                SLOT_SNAPSHOT: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
        end else begin
            if (wstb.control) ctrl_q   <= bus_wdata;
            if (wstb.period)  period_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && mapped) begin
            unique case (slot)
                SLOT_STATUS:   bus_rdata = status_word;
                SLOT_CONTROL:  bus_rdata = ctrl_q;
                SLOT_PERIOD:   bus_rdata = period_q;
                SLOT_SNAPSHOT: bus_rdata = count_val;
            endcase
        end
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_val,
    input  logic  ctl_wr,
    input  logic  ctl_start,
    input  logic  ctl_halt,
    input  logic  autoload,
    input  word_t period_q,
    output word_t count_q,
    output logic  run_q,
    output logic  expire
);
    word_t count_d;
    logic  run_d;
    logic  tick;

    assign tick   = run_q && !load;
    assign expire = tick && at_terminal(count_q);

    always_comb begin
        count_d = count_q;
        run_d   = run_q;
        if (load) begin
            count_d = load_val;
        end else if (tick) begin
            if (expire) begin
                if (autoload) begin
                    count_d = period_q;
                end else begin
                    count_d = '0;
                    run_d   = 1'b0;
                end
            end else begin
                count_d = count_q - word_t'(1);
            end
        end
        // start first, halt last: halt wins when both are written
        if (ctl_wr && ctl_start) run_d = 1'b1;
        if (ctl_wr && ctl_halt)  run_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            run_q   <= run_d;
        end
    end

endmodule

// File: rtl/cdt_status.sv
module cdt_status
    import cdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  expire,
    input  logic  clear,
    input  logic  irq_en,
    input  logic  running,
    output logic  timeout_q,
    output word_t status_word,
    output logic  irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            timeout_q <= 1'b0;
        end else if (expire) begin
            timeout_q <= 1'b1;
        end else if (clear) begin
            timeout_q <= 1'b0;
        end
    end

    assign status_word = pack_status(timeout_q, running);
    assign irq         = timeout_q && irq_en;

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    wstrobe_t wstb;
    word_t    ctrl_q;
    word_t    period_q;
    word_t    count_q;
    word_t    status_word;
    logic     run_q;
    logic     expire;
    logic     timeout_q;

    cdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .status_word (status_word),
        .count_val   (count_q),
        .wstb        (wstb),
        .ctrl_q      (ctrl_q),
        .period_q    (period_q),
        .bus_rdata   (bus_rdata)
    );

    cdt_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .load      (wstb.period),
        .load_val  (bus_wdata),
        .ctl_wr    (wstb.control),
        .ctl_start (bus_wdata[CB_START]),
        .ctl_halt  (bus_wdata[CB_HALT]),
        .autoload  (ctrl_q[CB_AUTO]),
        .period_q  (period_q),
        .count_q   (count_q),
        .run_q     (run_q),
        .expire    (expire)
    );

    cdt_status u_status (
        .clk         (clk),
        .rst         (rst),
        .expire      (expire),
        .clear       (wstb.status),
        .irq_en      (ctrl_q[CB_IRQ_EN]),
        .running     (run_q),
        .timeout_q   (timeout_q),
        .status_word (status_word),
        .irq         (irq)
    );

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       cnt,
    input logic              run,
    input logic              to_flag,
    input logic              ien,
    input logic              auto_mode,
    input logic              irq
);
    logic any_wr, per_wr, ctl_wr, stat_wr;
    assign any_wr  = bus_sel && bus_we;
    assign per_wr  = any_wr && (bus_addr[ADDR_W-1:2] == 2);
    assign ctl_wr  = any_wr && (bus_addr[ADDR_W-1:2] == 1);
    assign stat_wr = any_wr && (bus_addr[ADDR_W-1:2] == 0);

    p_halt_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && bus_wdata[3]) |=> !run);

    p_period_load_r5: assert property (@(posedge clk) disable iff (rst)
        per_wr |=> (cnt == $past(bus_wdata)));

    p_oneshot_halts_r6: assert property (@(posedge clk) disable iff (rst)
        (run && cnt <= 1 && !auto_mode && !any_wr) |=> (!run && to_flag && cnt == 0));

    p_timeout_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(to_flag) |-> $past(run));

    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (run && cnt > 1 && !any_wr) |=> (run && cnt == $past(cnt) - 1));

    p_status_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !run) |=> !to_flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (!ien || !to_flag) |-> !irq);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!run && !any_wr) |=> $stable(cnt));

endmodule

bind cdt_timer cdt_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (count_q),
    .run       (run_q),
    .to_flag   (timeout_q),
    .ien       (ctrl_q[0]),
    .auto_mode (ctrl_q[1]),
    .irq       (irq)
);

// File: tb/tb_cdt_timer.sv
module tb_cdt_timer;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned AW = 6;
    localparam logic [AW-1:0] A_STAT = 6'h00, A_CTRL = 6'h04,
                              A_PER  = 6'h08, A_SNAP = 6'h0C, A_HOLE = 6'h14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    cdt_timer #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // every bus task starts at a falling edge and consumes one rising edge
    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_CTRL, v); check("R1 control", v, 0);
        rd(A_PER,  v); check("R1 period", v, 0);
        rd(A_SNAP, v); check("R1 snapshot", v, 0);
    endtask

    task automatic t_decode();
        logic [31:0] v;
        wr(A_PER, 32'd77);
        wr(A_HOLE, 32'hDEAD_BEEF);
        rd(A_HOLE, v); check("R2 unmapped read", v, 0);
        rd(A_PER,  v); check("R2 unmapped write ignored", v, 77);
        wr(A_SNAP, 32'h1234);
        rd(A_SNAP, v); check("R2 snapshot write ignored", v, 77);
        rd(A_PER,  v); check("R5 period stored", v, 77);
    endtask

    task automatic t_start_stop();
        logic [31:0] v;
        wr(A_PER, 32'd5);
        wr(A_CTRL, 32'h0000_000C);
        rd(A_STAT, v); check("R4 start+stop halted", v, 0);
        rd(A_CTRL, v); check("R4 control as-is", v, 32'hC);
        idle(3);
        rd(A_SNAP, v); check("R9 hold while stopped", v, 5);
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, v); check("R4 upper bits stored", v, 32'hFFFF_FFF0);
        rd(A_STAT, v); check("R4 no start without bit2", v, 0);
    endtask

    task automatic t_stop_mid();
        logic [31:0] v;
        wr(A_PER, 32'd10);
        wr(A_CTRL, 32'h4);      // edge E0: count 10
        idle(2);                // E1, E2: count 8
        wr(A_CTRL, 32'h8);      // E3 decrements to 7 then halts
        idle(3);
        rd(A_SNAP, v); check("R9 stop after own decrement", v, 7);
        rd(A_STAT, v); check("R3 run bit clear", v, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(A_PER, 32'd4);
        wr(A_CTRL, 32'h4);
        idle(3);
        rd(A_STAT, v); check("R6 before P-th edge", v, 32'h2);
        rd(A_STAT, v); check("R6 timeout, halted", v, 32'h1);
        rd(A_SNAP, v); check("R6 count zero", v, 0);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R3 status clear", v, 0);
    endtask

    task automatic t_continuous();
        logic [31:0] v;
        wr(A_PER, 32'd3);
        wr(A_CTRL, 32'h6);      // E0
        idle(2);                // E1, E2
        rd(A_STAT, v); check("R7 before first expiry", v, 32'h2);   // E3 expires
        rd(A_SNAP, v); check("R7 reloaded", v, 3);                  // E4
        wr(A_STAT, 32'hFFFF_FFFF);                                  // E5
        rd(A_STAT, v); check("R3 clear keeps run", v, 32'h2);       // E6 expires
        rd(A_STAT, v); check("R7 second expiry", v, 32'h3);
        wr(A_CTRL, 32'h8);
        wr(A_STAT, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(A_PER, 32'd2);
        wr(A_CTRL, 32'h5);      // E0
        idle(1);                // E1
        check("R8 irq low before expiry", {31'd0, irq}, 0);
        idle(1);                // E2 expires
        check("R8 irq high", {31'd0, irq}, 1);
        wr(A_CTRL, 32'h0);
        check("R8 irq masked", {31'd0, irq}, 0);
        rd(A_STAT, v); check("R8 flag survives mask", v, 32'h1);
        wr(A_CTRL, 32'h1);
        check("R8 irq unmasked", {31'd0, irq}, 1);
        wr(A_STAT, 32'h0);
        check("R8 irq after clear", {31'd0, irq}, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_short_periods();
        logic [31:0] v;
        for (int p = 0; p < 2; p++) begin
            wr(A_PER, p);
            wr(A_CTRL, 32'h4);
            rd(A_STAT, v); check($sformatf("R10 p=%0d running", p), v, 32'h2);
            rd(A_STAT, v); check($sformatf("R10 p=%0d expired", p), v, 32'h1);
            wr(A_STAT, 32'h0);
        end
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(A_PER, 32'd2);
        wr(A_CTRL, 32'h4);      // E0
        idle(1);                // E1
        wr(A_STAT, 32'h0);      // E2: expiry and clear together
        rd(A_STAT, v); check("R11 set beats clear", v, 32'h1);
        wr(A_STAT, 32'h0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_start_stop();
        t_stop_mid();
        t_oneshot();
        t_continuous();
        t_irq();
        t_short_periods();
        t_set_wins();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4ns * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule